// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Butterfly Array

This block updates the path metrics of a radix-2 Viterbi decoder once per trellis step. It holds one signed 16-bit metric for every trellis state, either 16 states (constraint length 5) or 64 states (constraint length 7), fixed at elaboration. For each step it accepts one branch metric per butterfly. All butterflies are evaluated in parallel in a single clock. The block then registers the new metric array together with one survivor decision bit per new state.

Butterfly `i` reads the metrics of states `2i` (even) and `2i+1` (odd). It applies the branch metric `B` with opposite signs to the two predecessors. The first comparison writes new state `i`, in the lower half of the array, and the second writes new state `i + NUM_STATES/2`, in the upper half. Every add and subtract saturates to the signed 16-bit range. The registered metrics are both presented on the output and fed back as the predecessors of the next step. A downstream consumer takes the decision vector into its own survivor memory. Branch metric generation, normalisation and traceback are done elsewhere.

Top module: `viterbi_acs_array`

## Requirements
- R1: While reset is held and after it is released, before any step is accepted: `out_valid` is 0, `in_ready` is 1, `decisions` is all zero, state 0 holds metric 0, and every other state holds `INIT_LOW` (default -16384).
- R2: Call an accepted step's old metrics `E = M[2i]` and `O = M[2i+1]`, and its branch metric `B = bm[i]`. The new metric of state `i` is then max(sat(E+B), sat(O−B)), for every butterfly `i` in 0..NUM_STATES/2−1. Branch metric `i` sits at bits `[16i +: 16]` and state `s` at bits `[16s +: 16]`.
- R3: For the same step, the new metric of state `i + NUM_STATES/2` is max(sat(E−B), sat(O+B)).
- R4: Decision bit `i` is 1 exactly when sat(E+B) ≥ sat(O−B), and decision bit `i + NUM_STATES/2` is 1 exactly when sat(E−B) ≥ sat(O+B). A 1 means the even predecessor survived, so equal candidates give 1.
- R5: Every sum and difference saturates: results above 32767 become 32767 and results below −32768 become −32768, never wrapping.
- R6: A step accepted at a clock edge (`in_valid && in_ready`) has its results and `out_valid = 1` visible right after that same edge. With no new step accepted, `out_valid` falls after the edge at which `out_ready` is seen high.
- R7: `in_ready` is low while `out_valid` is high and `out_ready` is low. Such a step is ignored: metrics, decisions and `out_valid` stay unchanged.
- R8: A step offered while the held result is being consumed in the same cycle (`out_valid`, `out_ready` and `in_valid` all high) is accepted. It uses the presented metrics as its predecessors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A branch metric set is offered |
| in_ready | output | 1 | The offered step will be accepted at the next edge |
| branch_metrics | input | 16·NUM_STATES/2 | Signed branch metric per butterfly |
| out_valid | output | 1 | Presented metrics and decisions are a fresh, unconsumed result |
| out_ready | input | 1 | Consumer takes the presented result |
| state_metrics | output | 16·NUM_STATES | Signed metric per state |
| decisions | output | NUM_STATES | Survivor decision per new state |

## Verification
Two things can fall in the same cycle. The consumer can drain the held result while a new step is offered. Saturation at a rail can also coincide with an exact tie between two candidates. The bench provokes the first with directed back-to-back cycles, and with random streams in which `in_valid` and `out_ready` toggle independently. It provokes the second with full-scale branch metrics, which drive metrics into the rails so that both candidates clamp to the same value. A bench model with its own saturation and predecessor arithmetic judges every cycle. It compares the whole metric array, the decision vector and `out_valid`, and it checks that `in_ready` shows backpressure before each edge.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int METRIC_W = 16;

  typedef logic signed [METRIC_W-1:0] metric_t;

  localparam metric_t METRIC_MAX = {1'b0, {(METRIC_W-1){1'b1}}};
  localparam metric_t METRIC_MIN = {1'b1, {(METRIC_W-1){1'b0}}};

  // Saturating signed add.
  function automatic metric_t sat_add(metric_t a, metric_t b);
    logic [METRIC_W:0] s;
    s = {a[METRIC_W-1], a} + {b[METRIC_W-1], b};
    if (s[METRIC_W] != s[METRIC_W-1])
      return s[METRIC_W] ? METRIC_MIN : METRIC_MAX;
    return metric_t'(s[METRIC_W-1:0]);
  endfunction

  // Saturating signed subtract.
  function automatic metric_t sat_sub(metric_t a, metric_t b);
    logic [METRIC_W:0] s;
    s = {a[METRIC_W-1], a} - {b[METRIC_W-1], b};
    if (s[METRIC_W] != s[METRIC_W-1])
      return s[METRIC_W] ? METRIC_MIN : METRIC_MAX;
    return metric_t'(s[METRIC_W-1:0]);
  endfunction
endpackage

// File: rtl/acs_butterfly.sv
module acs_butterfly
  import acs_pkg::*;
(
  input  metric_t m_even,
  input  metric_t m_odd,
  input  metric_t bm,
  output metric_t new_lo,
  output metric_t new_hi,
  output logic    dec_lo,
  output logic    dec_hi
);
  metric_t even_plus, odd_minus, even_minus, odd_plus;

  always_comb begin
    even_plus  = sat_add(m_even, bm);
    odd_minus  = sat_sub(m_odd, bm);
    even_minus = sat_sub(m_even, bm);
    odd_plus   = sat_add(m_odd, bm);
  end

  // Ties go to the even predecessor.
  always_comb begin
    dec_lo = (even_plus >= odd_minus);
    dec_hi = (even_minus >= odd_plus);
    new_lo = dec_lo ? even_plus : odd_minus;
    new_hi = dec_hi ? even_minus : odd_plus;
  end
endmodule

// File: rtl/acs_handshake.sv
module acs_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic step_accept,
  output logic out_valid
);
  logic valid_d;

  always_comb begin
    in_ready    = !out_valid || out_ready;
    step_accept = in_valid && in_ready;
    valid_d     = out_valid;
    if (step_accept)
      valid_d = 1'b1;
    else if (out_ready)
      valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else
      out_valid <= valid_d;
  end
endmodule

// File: rtl/acs_state_bank.sv
module acs_state_bank
  import acs_pkg::*;
#(
  parameter int      NUM_STATES = 16,
  parameter metric_t INIT_LOW   = -16'sd16384,
  localparam int     FLAT_W     = NUM_STATES * METRIC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [FLAT_W-1:0]     metrics_d,
  input  logic [NUM_STATES-1:0] dec_d,
  output logic [FLAT_W-1:0]     metrics_q,
  output logic [NUM_STATES-1:0] dec_q
);
  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    localparam metric_t RST_VAL = (s == 0) ? metric_t'(0) : INIT_LOW;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        metrics_q[s*METRIC_W +: METRIC_W] <= RST_VAL;
        dec_q[s]                          <= 1'b0;
      end else if (load_en) begin
        metrics_q[s*METRIC_W +: METRIC_W] <= metrics_d[s*METRIC_W +: METRIC_W];
        dec_q[s]                          <= dec_d[s];
      end
    end
  end
endmodule

// File: rtl/viterbi_acs_array.sv
module viterbi_acs_array
  import acs_pkg::*;
#(
  parameter int      NUM_STATES = 16,
  parameter metric_t INIT_LOW   = -16'sd16384,
  localparam int     NUM_BFLY   = NUM_STATES / 2,
  localparam int     SM_W       = NUM_STATES * METRIC_W,
  localparam int     BM_W       = NUM_BFLY * METRIC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BM_W-1:0]       branch_metrics,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SM_W-1:0]       state_metrics,
  output logic [NUM_STATES-1:0] decisions
);
  logic                  step_accept;
  logic [SM_W-1:0]       metrics_next;
  logic [NUM_STATES-1:0] dec_next;

  acs_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .step_accept(step_accept),
    .out_valid  (out_valid)
  );

  // Predecessors 2i and 2i+1 feed new states i and i+NUM_BFLY.
  for (genvar i = 0; i < NUM_BFLY; i++) begin : g_bfly
    acs_butterfly u_bf (
      .m_even(metric_t'(state_metrics[(2*i)*METRIC_W +: METRIC_W])),
      .m_odd (metric_t'(state_metrics[(2*i+1)*METRIC_W +: METRIC_W])),
      .bm    (metric_t'(branch_metrics[i*METRIC_W +: METRIC_W])),
      .new_lo(metrics_next[i*METRIC_W +: METRIC_W]),
      .new_hi(metrics_next[(i+NUM_BFLY)*METRIC_W +: METRIC_W]),
      .dec_lo(dec_next[i]),
      .dec_hi(dec_next[i+NUM_BFLY])
    );
  end

  acs_state_bank #(
    .NUM_STATES(NUM_STATES),
    .INIT_LOW  (INIT_LOW)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (step_accept),
    .metrics_d(metrics_next),
    .dec_d    (dec_next),
    .metrics_q(state_metrics),
    .dec_q    (decisions)
  );
endmodule

// File: rtl/viterbi_acs_array_chk.sv
module viterbi_acs_array_chk
  import acs_pkg::*;
#(
  parameter int NUM_STATES = 16,
  localparam int SM_W = NUM_STATES * METRIC_W,
  localparam int BM_W = (NUM_STATES / 2) * METRIC_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [BM_W-1:0]       branch_metrics,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [SM_W-1:0]       state_metrics,
  input logic [NUM_STATES-1:0] decisions
);
  metric_t e0, o0, b0;
  assign e0 = metric_t'(state_metrics[0 +: METRIC_W]);
  assign o0 = metric_t'(state_metrics[METRIC_W +: METRIC_W]);
  assign b0 = metric_t'(branch_metrics[0 +: METRIC_W]);

  // R1 / R7: idle output never blocks the input side
  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6: an accepted step is presented after the edge
  a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6: consumed result without a new step drops out_valid
  a_r6_drop_on_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R7: a stalled result is held unchanged
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(state_metrics) && $stable(decisions)));

  // R2 / R4: state 0 takes the candidate its decision names
  a_r2_state0_select: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (metric_t'(state_metrics[0 +: METRIC_W]) ==
        (decisions[0] ? sat_add($past(e0), $past(b0))
                      : sat_sub($past(o0), $past(b0)))));
endmodule

bind viterbi_acs_array viterbi_acs_array_chk #(.NUM_STATES(NUM_STATES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .branch_metrics(branch_metrics),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .state_metrics (state_metrics),
  .decisions     (decisions)
);

// File: tb/viterbi_acs_array_tb.sv
`timescale 1ns/1ps
module viterbi_acs_array_tb;
  localparam int NS  = 16;
  localparam int NB  = NS / 2;
  localparam int W   = 16;
  localparam int INIT_LOW = -16384;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [NB*W-1:0] branch_metrics;
  logic            out_valid;
  logic            out_ready;
  logic [NS*W-1:0] state_metrics;
  logic [NS-1:0]   decisions;

  int checks = 0;
  int errors = 0;

  int exp_m [NS];
  bit exp_d [NS];
  bit exp_v;
  int bm_q  [NB];

  viterbi_acs_array #(.NUM_STATES(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .branch_metrics(branch_metrics), .out_valid(out_valid),
    .out_ready(out_ready), .state_metrics(state_metrics),
    .decisions(decisions)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int clamp(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Reference step: predecessors 2i, 2i+1; lower half from the first compare
  task automatic model_step();
    int nm [NS];
    bit nd [NS];
    for (int i = 0; i < NB; i++) begin
      int e, o, b, ep, om, em, op;
      e = exp_m[2*i]; o = exp_m[2*i+1]; b = bm_q[i];
      ep = clamp(e + b); om = clamp(o - b);
      em = clamp(e - b); op = clamp(o + b);
      nd[i]    = (ep >= om);
      nm[i]    = nd[i] ? ep : om;
      nd[i+NB] = (em >= op);
      nm[i+NB] = nd[i+NB] ? em : op;
    end
    exp_m = nm;
    exp_d = nd;
  endtask

  task automatic compare(string tag);
    int  bad_s;
    int  got;
    logic [NS-1:0] ed;
    bad_s = -1;
    for (int s = 0; s < NS; s++) begin
      got = int'($signed(state_metrics[s*W +: W]));
      ed[s] = exp_d[s];
      if (got != exp_m[s] && bad_s < 0) bad_s = s;
    end
    checks++;
    if (bad_s >= 0) begin
      errors++;
      $display("FAIL %s metric[%0d] actual %0d expected %0d", tag, bad_s,
               $signed(state_metrics[bad_s*W +: W]), exp_m[bad_s]);
    end
    checks++;
    if (decisions !== ed) begin
      errors++;
      $display("FAIL %s decisions actual %h expected %h", tag, decisions, ed);
    end
    checks++;
    if (out_valid !== exp_v) begin
      errors++;
      $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, exp_v);
    end
  endtask

  task automatic cycle(bit v, bit r, string tag);
    bit rdy_exp, acc;
    @(negedge clk);
    in_valid  = v;
    out_ready = r;
    for (int i = 0; i < NB; i++) branch_metrics[i*W +: W] = bm_q[i][W-1:0];
    #0.5;
    rdy_exp = !exp_v || r;
    checks++;
    if (in_ready !== rdy_exp) begin
      errors++;
      $display("FAIL R7 %s in_ready actual %b expected %b", tag, in_ready, rdy_exp);
    end
    acc = v && rdy_exp;
    @(posedge clk);
    #1;
    if (acc) begin
      model_step();
      exp_v = 1'b1;
    end else if (r) begin
      exp_v = 1'b0;
    end
    compare(tag);
  endtask

  task automatic set_bm_all(int val);
    for (int i = 0; i < NB; i++) bm_q[i] = val;
  endtask

  task automatic set_bm_rand(bit extreme);
    for (int i = 0; i < NB; i++) begin
      if (extreme && ($urandom % 4 == 0))
        bm_q[i] = ($urandom % 2) ? 32767 : -32768;
      else
        bm_q[i] = int'($urandom % 4001) - 2000;
    end
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; branch_metrics = '0;
    for (int s = 0; s < NS; s++) begin
      exp_m[s] = (s == 0) ? 0 : INIT_LOW;
      exp_d[s] = 1'b0;
    end
    exp_v = 1'b0;
    set_bm_all(0);
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset held");
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 in_ready actual %b expected 1", in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 after release");

    // R4: zero branch metric, equal predecessors tie to the even path
    set_bm_all(0);
    cycle(1, 1, "R4 tie");

    // R5: full-scale branch metrics push candidates into the rails
    set_bm_all(0);
    bm_q[0] = 32767; bm_q[1] = -32768; bm_q[2] = 32767; bm_q[NB-1] = -32768;
    cycle(1, 1, "R5 saturate");
    set_bm_all(32767);
    cycle(1, 1, "R5 saturate rail");
    set_bm_all(-32768);
    cycle(1, 1, "R5 saturate low rail");

    // R7: stall, offered steps are ignored
    set_bm_rand(0);
    cycle(1, 0, "R7 stall 1");
    set_bm_rand(0);
    cycle(1, 0, "R7 stall 2");
    cycle(0, 0, "R7 stall idle");

    // R8: consume and accept in the same cycle
    set_bm_rand(0);
    cycle(1, 1, "R8 drain+accept");
    set_bm_rand(0);
    cycle(1, 1, "R8 back-to-back");

    // R6: drain without new step, then idle
    cycle(0, 1, "R6 drain");
    cycle(0, 0, "R6 idle");
    set_bm_rand(0);
    cycle(1, 0, "R6 accept from idle");

    // R2 R3: random streams with independent valid/ready
    for (int n = 0; n < 400; n++) begin
      bit v, r;
      v = ($urandom % 4) != 0;
      r = ($urandom % 3) != 0;
      set_bm_rand(n > 300);
      cycle(v, r, (n % 2) ? "R2 random" : "R3 random");
    end

    // R1 again: reset mid-stream restores the start state
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int s = 0; s < NS; s++) begin
      exp_m[s] = (s == 0) ? 0 : INIT_LOW;
      exp_d[s] = 1'b0;
    end
    exp_v = 1'b0;
    #1;
    compare("R1 re-reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule